// File: doc/BRIEF.md
# Dual-Width Accumulator ALU

This block is the arithmetic and logic stage of an accumulator-style processor core. A single datapath handles either a narrow (half-width, 8-bit by default) or a wide (full-width, 16-bit by default) operand size, chosen per operation by a mode input. Each operation takes the accumulator, a memory operand and the incoming carry. It produces a result, a result-write strobe, a set of new flag values, and a mask that says which of the four flags the operation actually updates.

The operations are:
- add with carry and subtract with borrow
- compare
- the three bitwise logic functions
- bit test, and the two test-and-modify operations (set bits, clear bits)
- the four shifts and rotates, applied to the accumulator
- increment and decrement
- exchange of the accumulator's two bytes

Decimal arithmetic, operand fetch and instruction timing are handled elsewhere. Inputs are taken when `valid_i` is high, and all outputs are registered. The results of an operation therefore appear on the clock edge that follows its acceptance.

Top module: `acc_alu`

## Requirements
- R1: `op_i`=0 (add) gives A+M+carry_i at the active width. flags_o bit 0 (c) is the carry out of the active width. Bit 2 (v) is signed overflow. Mask is 4'b1111 (flag order {n,v,z,c} = bits 3..0) and res_we_o=1.
- R2: `op_i`=1 (subtract) gives A+~M+carry_i at the active width. c=1 means no borrow, v is signed overflow of that sum, the mask is 4'b1111 and the result is written.
- R3: `op_i`=2 (compare) evaluates A−M. It sets n from the difference MSB, z when A==M and c when A>=M unsigned. The mask is 4'b1011, so v is not touched, and res_we_o=0.
- R4: `op_i`=3/4/5 give A&M, A|M and A^M. Each is written, with mask 4'b1010: n is the result MSB and z is the zero test.
- R5: `op_i`=6 (bit test) never writes. z is set when A&M is zero, n is M's MSB and v is M's next bit, with mask 4'b1110. When bit_imm_i=1 the mask is 4'b0010.
- R6: `op_i`=7 writes M|A and `op_i`=8 writes M&~A. Both take z from the original A&M and use mask 4'b0010. In narrow mode the upper byte of the result is M's upper byte.
- R7: `op_i`=9 shifts A left by one and `op_i`=11 rotates A left, with carry_i entering bit 0. Both load c from the old active-width MSB and use mask 4'b1011.
- R8: `op_i`=10 shifts A right logically, so n is always 0. `op_i`=12 rotates A right, with carry_i entering bit 7 (narrow) or bit 15 (wide). Both load c from the old bit 0 and use mask 4'b1011.
- R9: `op_i`=13 and 14 increment and decrement A, wrapping at the active width, with mask 4'b1010.
- R10: `op_i`=15 swaps A's two bytes in both modes. It sets n from bit 7 and z from bits 7:0 of the new value, with mask 4'b1010.
- R11: With narrow_i=1, operations that write A (all written operations except 7, 8 and 15) pass A's upper byte to the result unchanged.
- R12: After reset all outputs are zero. An operation accepted on a clock edge appears on the outputs at the next edge with valid_o=1. When valid_i=0, valid_o goes to 0 and the other outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Accept the operation on this edge |
| op_i | input | 4 | Operation select (codes as in the requirements) |
| narrow_i | input | 1 | 1 = half-width operation, 0 = full width |
| bit_imm_i | input | 1 | Bit test in immediate form (z only) |
| acc_i | input | DW | Accumulator |
| opnd_i | input | DW | Memory operand |
| carry_i | input | 1 | Carry flag in |
| valid_o | output | 1 | Outputs hold a fresh result |
| res_o | output | DW | Result |
| res_we_o | output | 1 | Result is to be written back |
| flags_o | output | 4 | New {n,v,z,c} |
| flag_mask_o | output | 4 | Which of {n,v,z,c} to update |

## Verification
The bench builds the block with its default DW=16, so the half width is 8. Every operation can then be run in both the narrow and the wide mode through one instance. Each operation is swept over the operand values 0x0000, 0x007F, 0x0080, 0x00FF, 0x7FFF, 0x8000, 0xFFFF and 0x1234, with carry in at both 0 and 1, so carries, borrows and overflows happen at both bit 8 and bit 16. The 0x1234 pattern and the wide values also show whether the upper byte is kept in narrow mode, and which source supplies it.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_CMP = 4'd2,  OP_AND = 4'd3,
    OP_OR  = 4'd4,  OP_XOR = 4'd5,  OP_BIT = 4'd6,  OP_TSB = 4'd7,
    OP_TRB = 4'd8,  OP_ASL = 4'd9,  OP_LSR = 4'd10, OP_ROL = 4'd11,
    OP_ROR = 4'd12, OP_INC = 4'd13, OP_DEC = 4'd14, OP_XBA = 4'd15
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_V = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          inv_i,
  input  logic          cin_i,
  input  logic          narrow_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o,
  output logic          ovf_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] b_eff;
  logic [HW:0]   lo_sum;
  logic [DW:0]   full_sum;

  assign b_eff    = inv_i ? ~b_i : b_i;
  assign lo_sum   = {1'b0, a_i[HW-1:0]} + {1'b0, b_eff[HW-1:0]} + {{HW{1'b0}}, cin_i};
  assign full_sum = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_i};

  always_comb begin
    if (narrow_i) begin
      sum_o  = {{HW{1'b0}}, lo_sum[HW-1:0]};
      cout_o = lo_sum[HW];
      ovf_o  = (a_i[HW-1] == b_eff[HW-1]) && (lo_sum[HW-1] != a_i[HW-1]);
    end else begin
      sum_o  = full_sum[DW-1:0];
      cout_o = full_sum[DW];
      ovf_o  = (a_i[DW-1] == b_eff[DW-1]) && (full_sum[DW-1] != a_i[DW-1]);
    end
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op_i,
  input  logic          narrow_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          cin_i,
  output logic [DW-1:0] val_o,
  output logic          sh_cout_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] msk, aw, mw, asl_v, lsr_v, ror_v;
  logic          a_top;

  assign msk   = narrow_i ? {{HW{1'b0}}, {HW{1'b1}}} : {DW{1'b1}};
  assign aw    = a_i & msk;
  assign mw    = m_i & msk;
  assign a_top = narrow_i ? a_i[HW-1] : a_i[DW-1];
  assign asl_v = (aw << 1) & msk;
  assign lsr_v = aw >> 1;

  // carry enters at the active-width MSB
  always_comb begin
    ror_v = lsr_v;
    if (narrow_i) ror_v[HW-1] = cin_i;
    else          ror_v[DW-1] = cin_i;
  end

  always_comb begin
    val_o     = '0;
    sh_cout_o = 1'b0;
    unique case (op_i)
      OP_AND: val_o = aw & mw;
      OP_OR:  val_o = aw | mw;
      OP_XOR: val_o = aw ^ mw;
      OP_TSB: val_o = mw | aw;
      OP_TRB: val_o = mw & ~aw;
      OP_ASL: begin val_o = asl_v;                          sh_cout_o = a_top;  end
      OP_ROL: begin val_o = asl_v | {{DW-1{1'b0}}, cin_i};  sh_cout_o = a_top;  end
      OP_LSR: begin val_o = lsr_v;                          sh_cout_o = a_i[0]; end
      OP_ROR: begin val_o = ror_v;                          sh_cout_o = a_i[0]; end
      OP_INC: val_o = (aw + {{DW-1{1'b0}}, 1'b1}) & msk;
      OP_DEC: val_o = (aw - {{DW-1{1'b0}}, 1'b1}) & msk;
      OP_XBA: val_o = {a_i[HW-1:0], a_i[DW-1:HW]};
      default: val_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  alu_op_e       op_i,
  input  logic          narrow_i,
  input  logic          bit_imm_i,
  input  logic [DW-1:0] val_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          add_cout_i,
  input  logic          add_ovf_i,
  input  logic          sh_cout_i,
  output logic [3:0]    flags_o,
  output logic [3:0]    mask_o,
  output logic          we_o
);
  localparam int HW = DW / 2;

  logic [DW-1:0] msk;
  logic          and_zero, n, v, z, c;

  assign msk      = narrow_i ? {{HW{1'b0}}, {HW{1'b1}}} : {DW{1'b1}};
  assign and_zero = ((a_i & m_i & msk) == '0);

  always_comb begin
    n      = narrow_i ? val_i[HW-1] : val_i[DW-1];
    z      = ((val_i & msk) == '0);
    v      = 1'b0;
    c      = 1'b0;
    mask_o = 4'b0000;
    we_o   = 1'b0;
    unique case (op_i)
      OP_ADD, OP_SUB: begin we_o = 1'b1; mask_o = 4'b1111; c = add_cout_i; v = add_ovf_i; end
      OP_CMP:         begin mask_o = 4'b1011; c = add_cout_i; end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: begin we_o = 1'b1; mask_o = 4'b1010; end
      OP_BIT: begin
        mask_o = bit_imm_i ? 4'b0010 : 4'b1110;
        n      = narrow_i ? m_i[HW-1] : m_i[DW-1];
        v      = narrow_i ? m_i[HW-2] : m_i[DW-2];
        z      = and_zero;
      end
      OP_TSB, OP_TRB: begin we_o = 1'b1; mask_o = 4'b0010; z = and_zero; end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin we_o = 1'b1; mask_o = 4'b1011; c = sh_cout_i; end
      OP_XBA: begin
        we_o = 1'b1; mask_o = 4'b1010;
        n = val_i[HW-1];
        z = (val_i[HW-1:0] == '0);
      end
      default: ;
    endcase
  end

  assign flags_o = {n, v, z, c};
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [3:0]    op_i,
  input  logic          narrow_i,
  input  logic          bit_imm_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          carry_i,
  output logic          valid_o,
  output logic [DW-1:0] res_o,
  output logic          res_we_o,
  output logic [3:0]    flags_o,
  output logic [3:0]    flag_mask_o
);
  localparam int HW = DW / 2;

  alu_op_e       op;
  logic [DW-1:0] sum, unit_val, val, res_d, hi_src_w;
  logic          add_cout, add_ovf, sh_cout, we_d, is_arith, is_sub, add_cin;
  logic [3:0]    flags_d, mask_d;

  assign op       = alu_op_e'(op_i);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
  assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
  assign add_cin  = (op == OP_CMP) ? 1'b1 : carry_i;

  acc_alu_addsub #(.DW(DW)) u_addsub (
    .a_i(acc_i), .b_i(opnd_i), .inv_i(is_sub), .cin_i(add_cin),
    .narrow_i(narrow_i), .sum_o(sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  acc_alu_unit #(.DW(DW)) u_unit (
    .op_i(op), .narrow_i(narrow_i), .a_i(acc_i), .m_i(opnd_i),
    .cin_i(carry_i), .val_o(unit_val), .sh_cout_o(sh_cout)
  );

  assign val = is_arith ? sum : unit_val;

  acc_alu_flags #(.DW(DW)) u_flags (
    .op_i(op), .narrow_i(narrow_i), .bit_imm_i(bit_imm_i), .val_i(val),
    .a_i(acc_i), .m_i(opnd_i), .add_cout_i(add_cout), .add_ovf_i(add_ovf),
    .sh_cout_i(sh_cout), .flags_o(flags_d), .mask_o(mask_d), .we_o(we_d)
  );

  // narrow: upper byte comes from the written target, not the ALU
  assign hi_src_w = ((op == OP_TSB) || (op == OP_TRB)) ? opnd_i : acc_i;
  assign res_d    = (narrow_i && (op != OP_XBA)) ? {hi_src_w[DW-1:HW], val[HW-1:0]} : val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      res_o       <= '0;
      res_we_o    <= 1'b0;
      flags_o     <= '0;
      flag_mask_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_o       <= res_d;
        res_we_o    <= we_d;
        flags_o     <= flags_d;
        flag_mask_o <= mask_d;
      end
    end
  end

  // R3
  cmp_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ($past(op_i) == OP_CMP) |-> !res_we_o && !flag_mask_o[FLAG_V] && flag_mask_o[FLAG_C]);

  // R8
  lsr_n_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ($past(op_i) == OP_LSR) |-> !flags_o[FLAG_N]);

  // R6
  tst_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (($past(op_i) == OP_TSB) || ($past(op_i) == OP_TRB)) |-> (flag_mask_o == 4'b0010));

  // R11
  hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(narrow_i) && res_we_o &&
    !($past(op_i) inside {OP_TSB, OP_TRB, OP_XBA}) |-> (res_o[DW-1:HW] == $past(acc_i[DW-1:HW])));

  // R10
  xba_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ($past(op_i) == OP_XBA) |-> (res_o == {$past(acc_i[HW-1:0]), $past(acc_i[DW-1:HW])}));

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(res_o) && $stable(flags_o) && $stable(flag_mask_o));
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [3:0]    op_i = '0;
  logic          narrow_i = 1'b0, bit_imm_i = 1'b0, carry_i = 1'b0;
  logic [DW-1:0] acc_i = '0, opnd_i = '0;
  logic          valid_o, res_we_o;
  logic [DW-1:0] res_o;
  logic [3:0]    flags_o, flag_mask_o;

  int tests = 0;
  int fails = 0;

  logic [15:0] edge_v [8] = '{16'h0000, 16'h007F, 16'h0080, 16'h00FF,
                              16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

  always #2 clk = ~clk;

  acc_alu #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .narrow_i(narrow_i), .bit_imm_i(bit_imm_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .carry_i(carry_i), .valid_o(valid_o), .res_o(res_o), .res_we_o(res_we_o),
    .flags_o(flags_o), .flag_mask_o(flag_mask_o)
  );

  task automatic model(input logic [3:0] op, input logic nar, input logic imm,
                       input logic [15:0] a, input logic [15:0] m, input logic ci,
                       output logic [15:0] er, output logic ewe,
                       output logic [3:0] ef, output logic [3:0] emk);
    logic [15:0] msk, aw, mw, mb, r;
    logic [16:0] s;
    int top;
    logic n, v, z, c, nsp, zsp;
    msk = nar ? 16'h00FF : 16'hFFFF;
    top = nar ? 7 : 15;
    aw = a & msk; mw = m & msk; mb = (~m) & msk;
    r = '0; s = '0; n = 0; v = 0; z = 0; c = 0; nsp = 0; zsp = 0;
    ewe = 1'b1; emk = 4'b0000;
    case (op)
      4'd0: begin s = {1'b0, aw} + {1'b0, mw} + {16'b0, ci}; r = s[15:0] & msk;
              c = s[top+1]; v = (a[top] == m[top]) && (r[top] != a[top]); emk = 4'b1111; end
      4'd1: begin s = {1'b0, aw} + {1'b0, mb} + {16'b0, ci}; r = s[15:0] & msk;
              c = s[top+1]; v = (a[top] == mb[top]) && (r[top] != a[top]); emk = 4'b1111; end
      4'd2: begin s = {1'b0, aw} + {1'b0, mb} + 17'd1; r = s[15:0] & msk;
              c = (aw >= mw); ewe = 0; emk = 4'b1011; end
      4'd3: begin r = aw & mw; emk = 4'b1010; end
      4'd4: begin r = aw | mw; emk = 4'b1010; end
      4'd5: begin r = aw ^ mw; emk = 4'b1010; end
      4'd6: begin ewe = 0; emk = imm ? 4'b0010 : 4'b1110; nsp = 1; zsp = 1;
              n = m[top]; v = m[top-1]; z = ((aw & mw) == 0); end
      4'd7: begin r = mw | aw; emk = 4'b0010; zsp = 1; z = ((aw & mw) == 0); end
      4'd8: begin r = mw & ~aw & msk; emk = 4'b0010; zsp = 1; z = ((aw & mw) == 0); end
      4'd9:  begin r = (aw << 1) & msk; c = a[top]; emk = 4'b1011; end
      4'd10: begin r = aw >> 1; c = a[0]; emk = 4'b1011; end
      4'd11: begin r = ((aw << 1) & msk) | {15'b0, ci}; c = a[top]; emk = 4'b1011; end
      4'd12: begin r = (aw >> 1); r[top] = ci; c = a[0]; emk = 4'b1011; end
      4'd13: begin r = (aw + 16'd1) & msk; emk = 4'b1010; end
      4'd14: begin r = (aw - 16'd1) & msk; emk = 4'b1010; end
      default: begin r = {a[7:0], a[15:8]}; emk = 4'b1010; nsp = 1; zsp = 1;
              n = r[7]; z = (r[7:0] == 0); end
    endcase
    if (!nsp) n = r[top];
    if (!zsp) z = ((r & msk) == 0);
    if (op == 4'd15)                 er = r;
    else if (nar && (op == 4'd7 || op == 4'd8)) er = {m[15:8], r[7:0]};
    else if (nar)                    er = {a[15:8], r[7:0]};
    else                             er = r;
    ef = {n, v, z, c} & emk;
  endtask

  task automatic run_op(input logic [3:0] op, input logic nar, input logic imm,
                        input logic [15:0] a, input logic [15:0] m, input logic ci,
                        input string tag);
    logic [15:0] er; logic ewe; logic [3:0] ef, emk;
    model(op, nar, imm, a, m, ci, er, ewe, ef, emk);
    @(negedge clk);
    valid_i = 1; op_i = op; narrow_i = nar; bit_imm_i = imm;
    acc_i = a; opnd_i = m; carry_i = ci;
    @(negedge clk);
    tests++;
    if (valid_o !== 1'b1 || res_we_o !== ewe || flag_mask_o !== emk ||
        (flags_o & flag_mask_o) !== ef || (ewe && res_o !== er)) begin
      fails++;
      $display("FAIL %s op=%0d nar=%0b a=%h m=%h c=%0b: got v=%0b res=%h we=%0b f=%b mk=%b exp res=%h we=%0b f=%b mk=%b",
               tag, op, nar, a, m, ci, valid_o, res_o, res_we_o, flags_o & flag_mask_o,
               flag_mask_o, er, ewe, ef, emk);
    end
  endtask

  task automatic sweep(input logic [3:0] op, input logic imm, input string tag);
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int ci = 0; ci < 2; ci++)
            run_op(op, w[0], imm, edge_v[i], edge_v[j], ci[0], tag);
  endtask

  task automatic test_reset();
    tests++;
    if (valid_o !== 0 || res_o !== 0 || res_we_o !== 0 || flags_o !== 0 || flag_mask_o !== 0) begin
      fails++;
      $display("FAIL R12 reset: got v=%0b res=%h we=%0b f=%b mk=%b exp all zero",
               valid_o, res_o, res_we_o, flags_o, flag_mask_o);
    end
  endtask

  task automatic test_add();    sweep(4'd0, 0, "R1/R11 add");
    run_op(4'd0, 1, 0, 16'hAB7F, 16'h0001, 0, "R1 add 7F+1 overflow"); endtask
  task automatic test_sub();    sweep(4'd1, 0, "R2 sub"); endtask
  task automatic test_cmp();    sweep(4'd2, 0, "R3 cmp"); endtask
  task automatic test_logic();
    sweep(4'd3, 0, "R4 and"); sweep(4'd4, 0, "R4 or"); sweep(4'd5, 0, "R4 xor");
  endtask
  task automatic test_bit();    sweep(4'd6, 0, "R5 bit"); sweep(4'd6, 1, "R5 bit imm"); endtask
  task automatic test_tsb_trb(); sweep(4'd7, 0, "R6 tsb"); sweep(4'd8, 0, "R6 trb"); endtask
  task automatic test_shift_left(); sweep(4'd9, 0, "R7 asl"); sweep(4'd11, 0, "R7 rol"); endtask
  task automatic test_shift_right(); sweep(4'd10, 0, "R8 lsr"); sweep(4'd12, 0, "R8 ror"); endtask
  task automatic test_incdec(); sweep(4'd13, 0, "R9 inc"); sweep(4'd14, 0, "R9 dec"); endtask
  task automatic test_xba();    sweep(4'd15, 0, "R10 xba"); endtask

  task automatic test_hold();
    logic [15:0] r0; logic [3:0] f0, k0;
    run_op(4'd0, 0, 0, 16'h1234, 16'h1111, 0, "R12 hold setup");
    r0 = res_o; f0 = flags_o; k0 = flag_mask_o;
    valid_i = 0; acc_i = 16'hFFFF; opnd_i = 16'hFFFF; op_i = 4'd1;
    @(negedge clk); @(negedge clk);
    tests++;
    if (valid_o !== 0 || res_o !== r0 || flags_o !== f0 || flag_mask_o !== k0) begin
      fails++;
      $display("FAIL R12 hold: got v=%0b res=%h f=%b mk=%b exp v=0 res=%h f=%b mk=%b",
               valid_o, res_o, flags_o, flag_mask_o, r0, f0, k0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1;
    test_add();
    test_sub();
    test_cmp();
    test_logic();
    test_bit();
    test_tsb_trb();
    test_shift_left();
    test_shift_right();
    test_incdec();
    test_xba();
    test_hold();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule